// File: doc/BRIEF.md
# Scheduled-Update Register Front End for a 12-bit DAC

This block sits between a byte-wide register bus and a 12-bit voltage-mode converter. Software writes a low data byte, a high data byte and a control byte. The data bytes land first in holding registers. They move into the output latch as one unit only when the selected trigger fires, so the converter code changes in a single step.

The trigger is either a write to the high byte or a pulse on one of three timer-overflow inputs. The timer triggers give periodic updates that do not depend on software timing. A format field sets where the 12 valid bits sit inside the 16-bit byte pair. The enable bit is brought out to the analog stage, which uses it to tri-state its output and cut its supply current.

Top module: `dac_sched_latch`

## Requirements
- R1: After reset, `dac_code` is 0 and `dac_en` is 0. Reads of the low, high and control registers return 0, so the update mode is 0 and the format is 0.
- R2: Writing the low data register (address 0) does not change `dac_code`. Reading address 0 returns the last byte written there, even before that byte has been latched.
- R3: Reading the high data register (address 1) returns the high byte held in the output latch, not the byte waiting in the holding register.
- R4: In update mode 0, a write to address 1 latches the new high byte and the held low byte together. `dac_code` shows the new value on the first clock edge after the write.
- R5: In update modes 1, 2 and 3, the pair is latched only when `tmr_ovf[mode-1]` is high at a clock edge. Data writes and pulses on the other timer inputs leave `dac_code` unchanged.
- R6: In update mode 0, pulses on `tmr_ovf` leave `dac_code` unchanged.
- R7: With format value f, `dac_code` equals bits [11:0] of `{hi,lo} >> min(f,4)`. The format value is captured when the pair is latched, so changing the format afterwards does not move `dac_code`.
- R8: `dac_en` follows control bit 7 from the clock edge that writes the control register (address 2).
- R9: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read. The control register reads as {bit7 enable, bits6:5 zero, bits4:3 update mode, bits2:0 format}. Address 3 reads as 0.
- R10: `dac_code` changes only on the clock edge after a trigger. Both bytes change in that same edge, so a full-scale swing goes straight from 0x000 to 0xFFF and back with no mixed code in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| bus_addr | input | 2 | Register address: 0 low data, 1 high data, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_ovf | input | 3 | Timer-overflow pulses; bit k triggers in update mode k+1 |
| dac_code | output | 12 | Latched, aligned converter code |
| dac_en | output | 1 | Converter enable; low means output off |

## Verification
The assertions assume at most one bus strobe per cycle and a stable address for the whole strobe cycle. They also assume that a timer bit which is high at a clock edge is meant as one trigger event per edge. The stimulus drives every strobe and timer bit for exactly one cycle, between clock edges. It never overlaps a read with a write. It never pulses a timer in the same cycle as a data write, so the result of each trigger is decided only by the update mode in force.

// File: rtl/dacl_pkg.sv
`timescale 1ns/1ps
package dacl_pkg;
  localparam int DATA_W  = 8;
  localparam int CODE_W  = 12;
  localparam int MODE_W  = 2;
  localparam int FMT_W   = 3;
  localparam int NUM_TMR = 3;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dacl_regfile.sv
`timescale 1ns/1ps
module dacl_regfile
  import dacl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int MW = MODE_W,
  parameter int FW = FMT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lat_hi,
  output logic [DW-1:0] pre_lo,
  output logic [DW-1:0] pre_hi,
  output logic          lo_wr,
  output logic          hi_wr,
  output logic          en,
  output logic [MW-1:0] mode,
  output logic [FW-1:0] fmt,
  output logic [DW-1:0] rdata
);
  localparam int PAD_W = DW - 1 - MW - FW;

  logic          ctrl_wr;
  logic [DW-1:0] ctrl_view;
  logic [DW-1:0] rdata_nxt;

  // Write decode
  always_comb begin
    lo_wr   = wr && (addr == REG_LO);
    hi_wr   = wr && (addr == REG_HI);
    ctrl_wr = wr && (addr == REG_CTRL);
  end

  // Read mux: low returns holding byte, high returns latched byte
  always_comb begin
    ctrl_view = {en, {PAD_W{1'b0}}, mode, fmt};
    unique case (addr)
      REG_LO:   rdata_nxt = pre_lo;
      REG_HI:   rdata_nxt = lat_hi;
      REG_CTRL: rdata_nxt = ctrl_view;
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_lo <= '0;
      pre_hi <= '0;
    end else begin
      if (lo_wr) pre_lo <= wdata;
      if (hi_wr) pre_hi <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= '0;
      fmt  <= '0;
    end else if (ctrl_wr) begin
      en   <= wdata[DW-1];
      mode <= wdata[FW +: MW];
      fmt  <= wdata[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rdata_nxt;
  end
endmodule

// File: rtl/dacl_trigger.sv
`timescale 1ns/1ps
module dacl_trigger
  import dacl_pkg::*;
#(
  parameter int MW   = MODE_W,
  parameter int NTMR = NUM_TMR
) (
  input  logic [MW-1:0]   mode,
  input  logic            hi_wr,
  input  logic [NTMR-1:0] tmr_ovf,
  output logic            upd
);
  logic [NTMR-1:0] tmr_hit;

  // One selectable timer source per nonzero mode value
  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    assign tmr_hit[g] = (mode == MW'(g + 1)) && tmr_ovf[g];
  end

  always_comb begin
    upd = ((mode == '0) && hi_wr) || (|tmr_hit);
  end
endmodule

// File: rtl/dacl_latch.sv
`timescale 1ns/1ps
module dacl_latch
  import dacl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CODE_W,
  parameter int FW = FMT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] src_lo,
  input  logic [DW-1:0] src_hi,
  input  logic [FW-1:0] fmt,
  output logic [DW-1:0] lat_hi,
  output logic [CW-1:0] code
);
  localparam int PAIR_W = 2 * DW;
  localparam int MAX_SH = PAIR_W - CW;

  logic [DW-1:0]     lat_lo;
  logic [FW-1:0]     lat_fmt;
  logic [FW-1:0]     shamt;
  logic [PAIR_W-1:0] shifted;

  // Whole pair plus its format captured on one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_lo  <= '0;
      lat_hi  <= '0;
      lat_fmt <= '0;
    end else if (upd) begin
      lat_lo  <= src_lo;
      lat_hi  <= src_hi;
      lat_fmt <= fmt;
    end
  end

  // Justification: formats above the maximum shift saturate
  always_comb begin
    shamt   = (lat_fmt > FW'(MAX_SH)) ? FW'(MAX_SH) : lat_fmt;
    shifted = {lat_hi, lat_lo} >> shamt;
    code    = shifted[CW-1:0];
  end
endmodule

// File: rtl/dac_sched_latch.sv
`timescale 1ns/1ps
module dac_sched_latch
  import dacl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  output logic [CODE_W-1:0]  dac_code,
  output logic               dac_en
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [DATA_W-1:0] pre_lo;
  logic [DATA_W-1:0] pre_hi;
  logic [DATA_W-1:0] lat_hi;
  logic [DATA_W-1:0] src_lo;
  logic [DATA_W-1:0] src_hi;
  logic              lo_wr;
  logic              hi_wr;
  logic [MODE_W-1:0] mode;
  logic [FMT_W-1:0]  fmt;
  logic              upd;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  dacl_regfile #(.DW(DATA_W), .MW(MODE_W), .FW(FMT_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_i_n),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .wdata (bus_wdata),
    .lat_hi(lat_hi),
    .pre_lo(pre_lo),
    .pre_hi(pre_hi),
    .lo_wr (lo_wr),
    .hi_wr (hi_wr),
    .en    (dac_en),
    .mode  (mode),
    .fmt   (fmt),
    .rdata (bus_rdata)
  );

  dacl_trigger #(.MW(MODE_W), .NTMR(NUM_TMR)) u_trig (
    .mode   (mode),
    .hi_wr  (hi_wr),
    .tmr_ovf(tmr_ovf),
    .upd    (upd)
  );

  // A write landing in the trigger cycle is included in the latched pair
  always_comb begin
    src_lo = lo_wr ? bus_wdata : pre_lo;
    src_hi = hi_wr ? bus_wdata : pre_hi;
  end

  dacl_latch #(.DW(DATA_W), .CW(CODE_W), .FW(FMT_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_i_n),
    .upd   (upd),
    .src_lo(src_lo),
    .src_hi(src_hi),
    .fmt   (fmt),
    .lat_hi(lat_hi),
    .code  (dac_code)
  );
endmodule

// File: rtl/dacl_chk.sv
`timescale 1ns/1ps
module dacl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [2:0]  tmr_ovf,
  input logic [1:0]  mode,
  input logic        upd,
  input logic [7:0]  pre_lo,
  input logic [7:0]  lat_hi,
  input logic [11:0] dac_code,
  input logic        dac_en
);
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(dac_code));

  p_hi_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && mode == 2'd0) |=> lat_hi == $past(bus_wdata));

  p_lo_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |=> bus_rdata == $past(pre_lo));

  p_hi_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> bus_rdata == $past(lat_hi));

  p_en_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> dac_en == $past(bus_wdata[7]));

  p_timer_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && tmr_ovf == 3'd0) |=> $stable(dac_code));

  p_tmr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !(bus_wr && bus_addr == 2'd1)) |=> $stable(dac_code));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind dac_sched_latch dacl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .tmr_ovf  (tmr_ovf),
  .mode     (mode),
  .upd      (upd),
  .pre_lo   (pre_lo),
  .lat_hi   (lat_hi),
  .dac_code (dac_code),
  .dac_en   (dac_en)
);

// File: tb/dac_sched_latch_tb.sv
`timescale 1ns/1ps
module dac_sched_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr, rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [2:0]  tmr;
  logic [11:0] code;
  logic        en;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [11:0] cur_code;
  logic [7:0]  cur_hi;

  always #2.5 clk = ~clk;

  dac_sched_latch u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .tmr_ovf(tmr), .dac_code(code),
    .dac_en(en)
  );

  function automatic logic [11:0] ref_code(logic [7:0] hi, logic [7:0] lo, logic [2:0] f);
    int s;
    logic [15:0] p;
    s = (f > 3'd4) ? 4 : int'(f);
    p = {hi, lo} >> s;
    return p[11:0];
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [2:0] t);
    @(negedge clk); tmr = t;
    @(negedge clk); tmr = 3'd0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1", "code after reset", 16'(code), 16'h0);
    chk("R1", "enable after reset", 16'(en), 16'h0);
    bus_read(2'd0, d); chk("R1", "low read", 16'(d), 16'h0);
    bus_read(2'd1, d); chk("R1", "high read", 16'(d), 16'h0);
    bus_read(2'd2, d); chk("R1", "control read", 16'(d), 16'h0);
  endtask

  task automatic t_mode0;
    logic [7:0] d;
    bus_write(2'd2, 8'h80);
    chk("R8", "enable set", 16'(en), 16'h1);
    bus_write(2'd0, 8'h34);
    chk("R2", "low write no update", 16'(code), 16'h0);
    bus_read(2'd0, d); chk("R2", "low prelatch read", 16'(d), 16'h34);
    bus_write(2'd1, 8'h12);
    chk("R4", "high write update", 16'(code), 16'h234);
    bus_read(2'd1, d); chk("R3", "high latched read", 16'(d), 16'h12);
  endtask

  task automatic t_fullscale;
    bus_write(2'd0, 8'hFF); bus_write(2'd1, 8'h0F);
    chk("R10", "swing up", 16'(code), 16'hFFF);
    bus_write(2'd0, 8'h00);
    chk("R10", "no partial code", 16'(code), 16'hFFF);
    bus_write(2'd1, 8'h00);
    chk("R10", "swing down", 16'(code), 16'h000);
  endtask

  task automatic t_mode0_timer;
    bus_write(2'd0, 8'h66);
    pulse(3'b111);
    chk("R6", "timers ignored in mode 0", 16'(code), 16'h000);
  endtask

  task automatic t_timer_modes;
    logic [7:0] d, lo, hi;
    cur_code = 12'h000;
    cur_hi   = 8'h00;
    for (int m = 1; m <= 3; m++) begin
      lo = 8'(8'h10 * m + 1);
      hi = 8'(m + 4);
      bus_write(2'd2, 8'(8'h80 | (m << 3)));
      bus_write(2'd0, lo); bus_write(2'd1, hi);
      chk("R5", "data write no update", 16'(code), 16'(cur_code));
      bus_read(2'd1, d); chk("R3", "high reads old latch", 16'(d), 16'(cur_hi));
      pulse(3'(~(3'b001 << (m - 1))));
      chk("R5", "other timers ignored", 16'(code), 16'(cur_code));
      pulse(3'(3'b001 << (m - 1)));
      cur_code = ref_code(hi, lo, 3'd0);
      cur_hi   = hi;
      chk("R5", "selected timer update", 16'(code), 16'(cur_code));
    end
  endtask

  task automatic t_format;
    for (int f = 0; f < 8; f++) begin
      bus_write(2'd2, 8'(8'h80 | f));
      bus_write(2'd0, 8'h5A); bus_write(2'd1, 8'hC3);
      chk("R7", $sformatf("format %0d", f), 16'(code), 16'(ref_code(8'hC3, 8'h5A, 3'(f))));
    end
    bus_write(2'd2, 8'h80);
    chk("R7", "format captured at latch", 16'(code), 16'hC35);
    bus_write(2'd1, 8'hC3);
    chk("R7", "new format on next latch", 16'(code), 16'h35A);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, d); chk("R9", "control layout", 16'(d), 16'h9F);
    bus_write(2'd0, 8'h01);
    repeat (3) @(negedge clk);
    chk("R9", "read data holds", 16'(rdata), 16'h9F);
    bus_read(2'd3, d); chk("R9", "unused address", 16'(d), 16'h0);
    bus_write(2'd2, 8'h00);
    chk("R8", "enable cleared", 16'(en), 16'h0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0; tmr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode0();
    t_fullscale();
    t_mode0_timer();
    t_timer_modes();
    t_format();
    t_ctrl();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule